// File: doc/BRIEF.md
# Parallel NOR Erase and Program Sequencer

This block runs one erase or one single-word program on a parallel NOR flash array and reports the outcome. A request names the operation, the sector (its index for protection lookup and its base word address), a destination word address, the data word and a polling limit in clock cycles. The `cmd_family` input picks one of two command protocols. Family 0 writes its commands straight to the target and watches a ready bit. Family 1 opens every operation with a two-write unlock pair and detects completion when a toggling status bit stops changing.

The engine drives a simple synchronous bus. A read strobe on `fl_re` returns data on `fl_rdata` in the next cycle, and each cycle with `fl_we` high is one bus write. A program is preceded by a read of the destination, and it is refused if the data needs a 0 to become 1. An erase of a sector whose bit in `sect_protect` is set is skipped. Family 0 status is decoded into distinct error classes, and the device is then put back into array-read mode.

The port is `PORT_BYTES` wide and is built from chips `CHIP_BYTES` wide. A command byte is replicated into the low byte of every chip lane, and all other bytes are zero. Addresses are word addresses, and the unlock offsets are absolute word addresses.

Top module: `flash_cmd_sequencer`

## Requirements
- R1: A family-0 erase writes 0x50, then 0x20, then 0xD0, one per cycle, all to the sector base word address.
- R2: A family-1 erase writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30@sector base.
- R3: A family-0 program writes 0x50, then 0x40, then the raw data word, all to the destination address.
- R4: A family-1 program writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then the raw data word at the destination.
- R5: Before a program, the destination is read. If (read AND data) differs from data, the request ends with error code 2 and no bus write is made.
- R6: An erase whose `sect_protect[req_sector]` bit is set ends with error code 3 and makes no bus read or write.
- R7: Family 0 polls the target address (the sector base for an erase, the destination for a program). Completion is bit 7 set in every chip lane. After completion the status is decoded and 0xFF is written to the target.
- R8: Family 1 polls the target and completes when bit 6 of every lane is equal in two consecutive reads. It then ends with code 0 and writes nothing more.
- R9: If polling has run for at least `req_timeout` cycles without completion, the family's reset command (0xFF for family 0, 0xF0 for family 1) is written to the target and the code is 1.
- R10: Family-0 status decode. A status equal to 0x80 in every lane gives 0. Otherwise the first matching rule applies, where a bit counts as set if it is set in any lane: bit 1 gives 7 (locked block); bits 5 and 4 give 4 (sequence error); bit 5 gives 5 (erase failure); bit 4 gives 6 (locking error); bit 3 gives 8 (voltage fault); anything else gives 9.
- R11: Each command word carries the command byte in bits [8*CHIP_BYTES*k +: 8] of every lane k, and every other bit is zero.
- R12: A request is taken only while `busy` is low, and `req_valid` while busy has no effect. `done` is a one-cycle pulse with `err_code` valid, and `busy` falls in the next cycle.
- R13: After reset `busy`, `done`, `fl_we` and `fl_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_prog | input | 1 | 1 = program one word, 0 = erase sector |
| cmd_family | input | 1 | Command protocol select (0 ready-bit, 1 toggle-bit) |
| req_sector | input | $clog2(NUM_SECT) | Sector index for protection lookup |
| req_base | input | ADDR_W | Sector base word address |
| req_addr | input | ADDR_W | Program destination word address |
| req_data | input | 8*PORT_BYTES | Program data word |
| req_timeout | input | TMO_W | Polling limit in clock cycles |
| sect_protect | input | NUM_SECT | Per-sector protection bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 4 | Outcome code, valid with done |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | 8*PORT_BYTES | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8*PORT_BYTES | Flash read data, valid the cycle after fl_re |

## Verification
A wrong step index or family latch shows up on `fl_we` as a bad address or data word in the cycle that write is issued. The bench compares every bus write in that same cycle. A wrong polling decision or timer value does not show until the end of the operation, as a missing or extra reset write, a wrong `err_code` at `done`, or a timeout outside its bounds. The check therefore covers completion latency as well as the code. A broken idle gate appears as stray writes or a second `done` pulse within the cycles after the first operation.

// File: rtl/flash_cmd_sequencer.sv
module flash_cmd_sequencer #(
  parameter int ADDR_W     = 24,
  parameter int PORT_BYTES = 4,
  parameter int CHIP_BYTES = 2,
  parameter int NUM_SECT   = 64,
  parameter int TMO_W      = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_prog,
  input  logic                        cmd_family,
  input  logic [$clog2(NUM_SECT)-1:0] req_sector,
  input  logic [ADDR_W-1:0]           req_base,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [8*PORT_BYTES-1:0]     req_data,
  input  logic [TMO_W-1:0]            req_timeout,
  input  logic [NUM_SECT-1:0]         sect_protect,
  output logic                        busy,
  output logic                        done,
  output logic [3:0]                  err_code,
  output logic [ADDR_W-1:0]           fl_addr,
  output logic [8*PORT_BYTES-1:0]     fl_wdata,
  output logic                        fl_we,
  output logic                        fl_re,
  input  logic [8*PORT_BYTES-1:0]     fl_rdata
);
  localparam int DW    = 8 * PORT_BYTES;
  localparam int CW    = 8 * CHIP_BYTES;
  localparam int LANES = PORT_BYTES / CHIP_BYTES;
  localparam logic [ADDR_W-1:0] UNL_A = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] UNL_B = ADDR_W'(12'h2AA);

  localparam logic [3:0] E_OK = 4'd0, E_TMO = 4'd1, E_DIRTY = 4'd2, E_SKIP = 4'd3,
                         E_SEQ = 4'd4, E_ERASE = 4'd5, E_LOCKERR = 4'd6,
                         E_LOCKED = 4'd7, E_VPP = 4'd8, E_STAT = 4'd9;

  function automatic logic [DW-1:0] lanes(input logic [7:0] b);
    logic [DW-1:0] w;
    w = '0;
    for (int i = 0; i < LANES; i++) w[i*CW +: 8] = b;
    return w;
  endfunction

  function automatic logic any_lane(input logic [DW-1:0] w, input int b);
    logic r;
    r = 1'b0;
    for (int i = 0; i < LANES; i++) r = r | w[i*CW + b];
    return r;
  endfunction

  function automatic logic all_lane(input logic [DW-1:0] w, input int b);
    logic r;
    r = 1'b1;
    for (int i = 0; i < LANES; i++) r = r & w[i*CW + b];
    return r;
  endfunction

  function automatic logic [3:0] decode(input logic [DW-1:0] s);
    if (s == lanes(8'h80))                 return E_OK;
    if (any_lane(s, 1))                    return E_LOCKED;
    if (any_lane(s, 5) && any_lane(s, 4))  return E_SEQ;
    if (any_lane(s, 5))                    return E_ERASE;
    if (any_lane(s, 4))                    return E_LOCKERR;
    if (any_lane(s, 3))                    return E_VPP;
    return E_STAT;
  endfunction

  typedef enum logic [2:0] {
    S_IDLE, S_PRE_RD, S_PRE_CHK, S_SEQ, S_POLL_RD, S_POLL_CHK, S_RST, S_FIN
  } state_t;

  state_t            state;
  logic              op_q, fam_q, have_prev;
  logic [ADDR_W-1:0] base_q, dest_q;
  logic [DW-1:0]     data_q, prev_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [TMO_W:0]    timer_q;
  logic [2:0]        step_q;
  logic [3:0]        err_q;

  logic [ADDR_W-1:0] tgt, st_addr;
  logic [7:0]        st_byte;
  logic              st_data, st_last;
  logic              rdy_bit, stable6, complete;
  logic [DW-1:0]     lane_mask;

  assign tgt       = op_q ? dest_q : base_q;
  assign lane_mask = lanes(8'hFF);

  always_comb begin
    st_addr = tgt;
    st_byte = 8'h00;
    st_data = 1'b0;
    st_last = 1'b0;
    if (!fam_q) begin
      case (step_q)
        3'd0:    st_byte = 8'h50;
        3'd1:    st_byte = op_q ? 8'h40 : 8'h20;
        default: begin
          st_last = 1'b1;
          if (op_q) st_data = 1'b1;
          else      st_byte = 8'hD0;
        end
      endcase
    end else begin
      case (step_q)
        3'd0: begin st_addr = UNL_A; st_byte = 8'hAA; end
        3'd1: begin st_addr = UNL_B; st_byte = 8'h55; end
        3'd2: begin st_addr = UNL_A; st_byte = op_q ? 8'hA0 : 8'h80; end
        3'd3: begin
          if (op_q) begin st_data = 1'b1; st_last = 1'b1; end
          else begin st_addr = UNL_A; st_byte = 8'hAA; end
        end
        3'd4: begin st_addr = UNL_B; st_byte = 8'h55; end
        default: begin st_byte = 8'h30; st_last = 1'b1; end
      endcase
    end
  end

  assign rdy_bit  = all_lane(fl_rdata, 7);
  assign stable6  = have_prev && (((fl_rdata ^ prev_q) & lanes(8'h40)) == '0);
  assign complete = fam_q ? stable6 : rdy_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= 1'b0;
      fam_q     <= 1'b0;
      have_prev <= 1'b0;
      base_q    <= '0;
      dest_q    <= '0;
      data_q    <= '0;
      prev_q    <= '0;
      tmo_q     <= '0;
      timer_q   <= '0;
      step_q    <= '0;
      err_q     <= E_OK;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_q   <= req_prog;
          fam_q  <= cmd_family;
          base_q <= req_base;
          dest_q <= req_addr;
          data_q <= req_data;
          tmo_q  <= req_timeout;
          step_q <= '0;
          err_q  <= E_OK;
          if (!req_prog && sect_protect[req_sector]) begin
            err_q <= E_SKIP;
            state <= S_FIN;
          end else if (req_prog) state <= S_PRE_RD;
          else                   state <= S_SEQ;
        end
        S_PRE_RD: state <= S_PRE_CHK;
        S_PRE_CHK: begin
          if ((fl_rdata & data_q) != data_q) begin
            err_q <= E_DIRTY;
            state <= S_FIN;
          end else state <= S_SEQ;
        end
        S_SEQ: begin
          if (st_last) begin
            state     <= S_POLL_RD;
            timer_q   <= '0;
            have_prev <= 1'b0;
          end else step_q <= step_q + 3'd1;
        end
        S_POLL_RD: begin
          timer_q <= timer_q + 1'b1;
          state   <= S_POLL_CHK;
        end
        S_POLL_CHK: begin
          timer_q   <= timer_q + 1'b1;
          prev_q    <= fl_rdata;
          have_prev <= 1'b1;
          if (complete) begin
            if (fam_q) begin
              err_q <= E_OK;
              state <= S_FIN;
            end else begin
              err_q <= decode(fl_rdata);
              state <= S_RST;
            end
          end else if (timer_q >= {1'b0, tmo_q}) begin
            err_q <= E_TMO;
            state <= S_RST;
          end else state <= S_POLL_RD;
        end
        S_RST:   state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);
  assign err_code = err_q;
  assign fl_we    = (state == S_SEQ) || (state == S_RST);
  assign fl_re    = (state == S_PRE_RD) || (state == S_POLL_RD);
  assign fl_addr  = (state == S_SEQ) ? st_addr : tgt;
  assign fl_wdata = (state == S_SEQ) ? (st_data ? data_q : lanes(st_byte))
                                     : lanes(fam_q ? 8'hF0 : 8'hFF);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_then_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_hold_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(base_q) && $stable(dest_q) && $stable(op_q) && $stable(fam_q)));
  p_skip_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == E_SKIP) |-> (!$past(fl_we) && !$past(fl_re)));
  p_dirty_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == E_DIRTY) |-> (!$past(fl_we) && $past(fl_re, 2)));
  p_timeout_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == E_TMO) |-> ($past(fl_we) && $past(fl_addr) == tgt));
  p_cmd_lanes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && !(state == S_SEQ && st_data)) |-> ((fl_wdata & ~lane_mask) == '0));
endmodule

// File: tb/flash_cmd_sequencer_test.sv
module flash_cmd_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_prog = 1'b0, cmd_family = 1'b0;
  logic [5:0]  req_sector = '0;
  logic [23:0] req_base = '0, req_addr = '0;
  logic [31:0] req_data = '0;
  logic [19:0] req_timeout = '0;
  logic [63:0] sect_protect = 64'h20;
  logic        busy, done, fl_we, fl_re;
  logic [3:0]  err_code;
  logic [23:0] fl_addr;
  logic [31:0] fl_wdata;
  logic [31:0] fl_rdata = '0;

  flash_cmd_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prog(req_prog),
    .cmd_family(cmd_family), .req_sector(req_sector), .req_base(req_base),
    .req_addr(req_addr), .req_data(req_data), .req_timeout(req_timeout),
    .sect_protect(sect_protect), .busy(busy), .done(done), .err_code(err_code),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, wr_seen = 0;
  logic [55:0] expq[$];

  // device model: array data before any write, then busy status, then final status
  logic        arm = 1'b0, dev_fam = 1'b0, dev_never = 1'b0, tog = 1'b0;
  int          arm_len = 0, bleft = 0, wcount = 0;
  logic [31:0] pre_val = '0, fin_val = '0;

  always @(posedge clk) begin
    if (arm) begin
      wcount <= 0; bleft <= arm_len; tog <= 1'b0;
    end else begin
      if (fl_we) wcount <= wcount + 1;
      if (fl_re) begin
        if (wcount == 0) fl_rdata <= pre_val;
        else if (dev_never || bleft > 0) begin
          if (!dev_never) bleft <= bleft - 1;
          tog <= ~tog;
          fl_rdata <= (dev_fam && tog) ? 32'h0040_0040 : 32'h0;
        end else fl_rdata <= fin_val;
      end
    end
  end

  function automatic logic [31:0] cw(input logic [7:0] b);
    return {8'h00, b, 8'h00, b};
  endfunction

  function automatic logic [3:0] model_decode(input logic [31:0] s);
    logic [15:0] o;
    o = s[31:16] | s[15:0];
    if (s == 32'h0080_0080) return 4'd0;
    if (o[1]) return 4'd7;
    if (o[5] && o[4]) return 4'd4;
    if (o[5]) return 4'd5;
    if (o[4]) return 4'd6;
    if (o[3]) return 4'd8;
    return 4'd9;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // every clock: each bus write must match the head of the expected list
  always @(negedge clk) begin
    cyc++;
    if (rst_n && fl_we) begin
      wr_seen++;
      if (expq.size() == 0) check(1'b0, "R12", "unexpected write", {fl_addr, fl_wdata}, 0);
      else begin
        logic [55:0] e;
        e = expq.pop_front();
        check({fl_addr, fl_wdata} == e, "R1-write", "bus write", {fl_addr, fl_wdata}, e);
      end
    end
    if (cyc > 150000) begin
      check(1'b0, "WD", "watchdog expired", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input string tag, input bit prog, input bit fam, input logic [5:0] sect,
                        input logic [23:0] base, input logic [23:0] dest,
                        input logic [31:0] data, input logic [31:0] pre, input int tmo,
                        input int blen, input bit never, input logic [31:0] fin, input bit poke);
    logic [3:0]  xerr;
    logic [23:0] t;
    int          lat;
    int          extra;
    bit          got;
    t = prog ? dest : base;
    expq.delete();
    if (!prog && sect_protect[sect]) xerr = 4'd3;
    else if (prog && ((pre & data) != data)) xerr = 4'd2;
    else begin
      if (!fam) begin
        expq.push_back({t, cw(8'h50)});
        expq.push_back({t, prog ? cw(8'h40) : cw(8'h20)});
        expq.push_back({t, prog ? data : cw(8'hD0)});
      end else begin
        expq.push_back({24'h555, cw(8'hAA)});
        expq.push_back({24'h2AA, cw(8'h55)});
        expq.push_back({24'h555, prog ? cw(8'hA0) : cw(8'h80)});
        if (prog) expq.push_back({dest, data});
        else begin
          expq.push_back({24'h555, cw(8'hAA)});
          expq.push_back({24'h2AA, cw(8'h55)});
          expq.push_back({base, cw(8'h30)});
        end
      end
      if (never) xerr = 4'd1;
      else xerr = fam ? 4'd0 : model_decode(fin);
      if (!fam) expq.push_back({t, cw(8'hFF)});
      else if (never) expq.push_back({t, cw(8'hF0)});
    end
    @(negedge clk);
    dev_fam = fam; dev_never = never; pre_val = pre; fin_val = fin; arm_len = blen; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0; wr_seen = 0;
    req_valid = 1'b1; req_prog = prog; cmd_family = fam; req_sector = sect;
    req_base = base; req_addr = dest; req_data = data; req_timeout = 20'(tmo);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; got = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (poke && i == 3) begin
        req_valid = 1'b1; req_prog = 1'b1; cmd_family = 1'b0; req_addr = 24'h000777;
      end
      if (poke && i == 4) req_valid = 1'b0;
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
      lat++;
    end
    check(got, tag, "done seen", got, 1);
    check(err_code == xerr, tag, "err_code", err_code, xerr);
    if (never) begin
      check(lat >= tmo && lat <= tmo + 14, "R9", "timeout latency", lat, tmo);
    end
    @(negedge clk);
    check(!done && !busy, "R12", "done single pulse then idle", {done, busy}, 0);
    extra = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    check(extra == 0, "R12", "no activity after done", extra, 0);
    check(expq.size() == 0, tag, "missing writes", expq.size(), 0);
    if (xerr == 4'd2 || xerr == 4'd3)
      check(wr_seen == 0, xerr == 4'd2 ? "R5" : "R6", "writes on refused request", wr_seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !fl_we && !fl_re, "R13", "reset outputs",
          {busy, done, fl_we, fl_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R13", "idle after reset", {busy, done}, 0);

    run_op("R1 R7 R11", 0, 0, 6'd2, 24'h010000, 24'h0, 32'h0, 32'h0, 100, 3, 0, 32'h0080_0080, 0);
    run_op("R2 R8", 0, 1, 6'd3, 24'h018000, 24'h0, 32'h0, 32'h0, 100, 4, 0, 32'h0000_0000, 0);
    run_op("R3 R7", 1, 0, 6'd0, 24'h0, 24'h020010, 32'h1234_5678, 32'hFFFF_FFFF, 100, 2, 0,
           32'h0080_0080, 0);
    run_op("R4 R5", 1, 1, 6'd0, 24'h0, 24'h020020, 32'h1030_ABCD, 32'hF0F0_FFFF, 100, 5, 0,
           32'h1030_ABCD, 0);
    run_op("R5", 1, 0, 6'd0, 24'h0, 24'h020030, 32'h0001_0000, 32'h0000_FFFF, 100, 2, 0,
           32'h0080_0080, 0);
    run_op("R6", 0, 0, 6'd5, 24'h028000, 24'h0, 32'h0, 32'h0, 100, 2, 0, 32'h0080_0080, 0);
    run_op("R9 family0", 0, 0, 6'd1, 24'h008000, 24'h0, 32'h0, 32'h0, 40, 0, 1, 32'h0, 0);
    run_op("R9 family1", 1, 1, 6'd0, 24'h0, 24'h020040, 32'h0000_00FF, 32'hFFFF_FFFF, 33, 0, 1,
           32'h0, 0);
    run_op("R10 seq", 0, 0, 6'd4, 24'h020000, 24'h0, 32'h0, 32'h0, 100, 1, 0, 32'h00B0_0080, 0);
    run_op("R10 erase", 0, 0, 6'd4, 24'h020000, 24'h0, 32'h0, 32'h0, 100, 1, 0, 32'h00A0_00A0, 0);
    run_op("R10 lock", 0, 0, 6'd4, 24'h020000, 24'h0, 32'h0, 32'h0, 100, 1, 0, 32'h0090_0080, 0);
    run_op("R10 locked", 0, 0, 6'd4, 24'h020000, 24'h0, 32'h0, 32'h0, 100, 1, 0, 32'h00B2_0080, 0);
    run_op("R10 vpp", 0, 0, 6'd4, 24'h020000, 24'h0, 32'h0, 32'h0, 100, 1, 0, 32'h0088_0080, 0);
    run_op("R10 other", 0, 0, 6'd4, 24'h020000, 24'h0, 32'h0, 32'h0, 100, 1, 0, 32'h00C0_0080, 0);
    run_op("R12 busy ignore", 0, 0, 6'd7, 24'h038000, 24'h0, 32'h0, 32'h0, 200, 10, 0,
           32'h0080_0080, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule